// File: doc/BRIEF.md
# Serial DAC Channel-Update Sequencer

This block is the controller side of a three-wire link to a multichannel digital-to-analog converter. A client hands it one channel update at a time: a 5-bit channel number and a 14-bit code, offered with a valid/ready handshake. When it accepts a request, the block pulls the frame strobe low. It derives a serial clock from the system clock by counting half periods, and it shifts out a 19-bit word. The channel number comes first and the code follows, each with its most significant bit first. Data moves only on rising serial-clock edges, so it is stable whenever the converter samples on a falling edge.

Once the last bit has gone out, the strobe returns high. The block then waits out a recovery interval, counted from the last falling clock edge, before it accepts the next request. A padded mode suits hosts that think in bytes. In that mode the frame grows to 24 clocks, the 19 valid bits lead, and five zero bits trail. The converter ignores these trailing bits. Parameters set the half-period divider and the recovery interval in system cycles. The block refuses to elaborate if they are too short for the given system clock period, or if the interval is not longer than one half period.

The controller is a five-state machine. IDLE waits for a request. LEAD holds the strobe low with the clock high for one half period. LOW and HIGH alternate for each bit. REST waits out the recovery interval. The transitions are: IDLE to LEAD on acceptance; LEAD to LOW at the end of the half period, which is the first falling edge; LOW to HIGH when bits remain, a rising edge that shifts in the next bit; HIGH to LOW, a falling edge; LOW to REST after the final bit, when both the clock and the strobe rise; and REST to IDLE when the recovery timer expires.

Top module: `dacseq_master`

## Requirements
- R1: After reset, dac_sync_n and dac_sclk are 1, dac_sdata is 0, req_ready is 1 and busy is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle, req_ready is 0 and busy is 1 until the recovery interval has elapsed.
- R3: The frame carries bits 18..14 = channel and bits 13..0 = code, sent in that order, most significant bit first. dac_sdata changes only when dac_sclk rises or when the strobe falls, so it holds steady across every falling clock edge.
- R4: dac_sync_n falls in the cycle after acceptance. The first falling edge of dac_sclk follows HALF_DIV cycles later.
- R5: Inside a frame, every high and low phase of dac_sclk lasts exactly HALF_DIV cycles. dac_sclk is 1 whenever dac_sync_n is 1.
- R6: With pad_mode = 0 at acceptance a frame has 19 falling clock edges. With pad_mode = 1 it has 24, and bits 4..0 of the 24-bit frame are 0.
- R7: dac_sync_n rises HALF_DIV cycles after the last falling clock edge of the frame, together with dac_sclk rising.
- R8: req_ready returns exactly GAP_CYCLES + 1 cycles after the last falling clock edge. The next strobe fall therefore comes at least GAP_CYCLES + 2 cycles after that edge.
- R9: pad_mode, req_chan and req_code are sampled only at acceptance. Changing them during a frame has no effect on that frame.
- R10: req_valid asserted while req_ready is 0 is ignored and produces no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request offered |
| req_chan | input | CHAN_W | Channel number of the update |
| req_code | input | CODE_W | Converter code of the update |
| pad_mode | input | 1 | 1: pad the frame to PAD_FRAME_W clocks |
| req_ready | output | 1 | Block can accept a request this cycle |
| busy | output | 1 | Frame or recovery interval in progress |
| dac_sync_n | output | 1 | Frame strobe, active low |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdata | output | 1 | Serial data, changes on rising dac_sclk |

## Verification
The bench decodes every frame at the pins and goes after several corner cases:
- Back-to-back requests held valid while the block is busy. A recovery timer that started at the wrong edge, or that ended one cycle early, would show up here as a ready rise or a strobe fall one cycle away from the expected spot.
- Junk requests and a flipped pad_mode during a frame. A design that resampled its inputs mid-frame would send a corrupted or wrongly sized frame; a design that accepted while busy would send an extra frame.
- All-ones and all-zeros words, and alternating-bit words in both modes. These expose a bit-count error at 19 versus 24, a missed first bit after the lead phase, and nonzero padding.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_REST
    } seq_state_e;

    // Interface timing limits of the converter port, in picoseconds
    localparam int unsigned MIN_PHASE_PS  = 13000;
    localparam int unsigned MIN_PERIOD_PS = 33334;
    localparam int unsigned MIN_GAP_PS    = 280000;

endpackage

// File: rtl/dacseq_halfclk.sv
// Half-period timer of the serial clock: pulses half_done on the last
// cycle of each HALF_DIV-cycle phase while run is held.
module dacseq_halfclk #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_done
);

    localparam int unsigned CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt;

    assign half_done = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || half_done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/dacseq_gap.sv
// Recovery timer: loaded on the final falling serial-clock edge, counts down.
module dacseq_gap #(
    parameter int unsigned GAP_CYCLES = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int unsigned CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] remain;

    assign expired = (remain == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(GAP_CYCLES);
        end else if (!expired) begin
            remain <= remain - CW'(1);
        end
    end

endmodule

// File: rtl/dacseq_shreg.sv
// Frame shift register: word loaded left-justified, zero padded, MSB out.
module dacseq_shreg #(
    parameter int unsigned WORD_W  = 19,
    parameter int unsigned FRAME_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    output logic              sdata
);

    localparam int unsigned PAD_W = FRAME_W - WORD_W;

    logic [FRAME_W-1:0] sr;
    logic [FRAME_W-1:0] load_val;

    generate
        if (PAD_W > 0) begin : g_pad
            assign load_val = {word, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign load_val = word;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {sr[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdata = sr[FRAME_W-1];

endmodule

// File: rtl/dacseq_master.sv
module dacseq_master
    import dacseq_pkg::*;
#(
    parameter int unsigned CHAN_W        = 5,
    parameter int unsigned CODE_W        = 14,
    parameter int unsigned PAD_FRAME_W   = 24,
    parameter int unsigned SYS_PERIOD_PS = 10000,
    parameter int unsigned HALF_DIV      = 2,
    parameter int unsigned GAP_CYCLES    = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [CODE_W-1:0] req_code,
    input  logic              pad_mode,
    output logic              req_ready,
    output logic              busy,
    output logic              dac_sync_n,
    output logic              dac_sclk,
    output logic              dac_sdata
);

    localparam int unsigned WORD_W = CHAN_W + CODE_W;
    localparam int unsigned BW     = $clog2(PAD_FRAME_W + 1);

    // Parameter legality against the port timing limits
    generate
        if (HALF_DIV < 1 || HALF_DIV * SYS_PERIOD_PS < MIN_PHASE_PS ||
            2 * HALF_DIV * SYS_PERIOD_PS < MIN_PERIOD_PS) begin : g_bad_div
            $error("dacseq_master: HALF_DIV too small for serial clock limits");
        end
        if (GAP_CYCLES * SYS_PERIOD_PS < MIN_GAP_PS || GAP_CYCLES <= HALF_DIV) begin : g_bad_gap
            $error("dacseq_master: GAP_CYCLES too small for recovery interval");
        end
        if (PAD_FRAME_W < WORD_W) begin : g_bad_pad
            $error("dacseq_master: padded frame shorter than word");
        end
    endgenerate

    seq_state_e state, state_nxt;

    logic          accept;
    logic          half_done;
    logic          gap_expired;
    logic          fall_evt;
    logic          rise_evt;
    logic          end_evt;
    logic          phase_run;
    logic [BW-1:0] bits_left;
    logic          sclk_q;
    logic          sync_q;

    assign accept    = req_valid && (state == ST_IDLE);
    assign phase_run = (state == ST_LEAD) || (state == ST_LOW) || (state == ST_HIGH);
    assign fall_evt  = half_done && ((state == ST_LEAD) || (state == ST_HIGH));
    assign rise_evt  = half_done && (state == ST_LOW) && (bits_left != '0);
    assign end_evt   = half_done && (state == ST_LOW) && (bits_left == '0);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept)      state_nxt = ST_LEAD;
            ST_LEAD: if (half_done)   state_nxt = ST_LOW;
            ST_LOW:  if (half_done)   state_nxt = (bits_left == '0) ? ST_REST : ST_HIGH;
            ST_HIGH: if (half_done)   state_nxt = ST_LOW;
            ST_REST: if (gap_expired) state_nxt = ST_IDLE;
            default:                  state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Remaining falling edges in the frame, set from pad_mode at acceptance (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_left <= '0;
        end else if (accept) begin
            bits_left <= pad_mode ? BW'(PAD_FRAME_W) : BW'(WORD_W);
        end else if (fall_evt) begin
            bits_left <= bits_left - BW'(1);
        end
    end

    // Output register: strobe and serial clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            if (accept) begin
                sync_q <= 1'b0;
            end
            if (fall_evt) begin
                sclk_q <= 1'b0;
            end
            if (rise_evt) begin
                sclk_q <= 1'b1;
            end
            if (end_evt) begin
                sclk_q <= 1'b1;
                sync_q <= 1'b1;
            end
        end
    end

    dacseq_halfclk #(
        .HALF_DIV (HALF_DIV)
    ) u_halfclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (phase_run),
        .half_done (half_done)
    );

    dacseq_gap #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fall_evt && (bits_left == BW'(1))),
        .expired (gap_expired)
    );

    dacseq_shreg #(
        .WORD_W  (WORD_W),
        .FRAME_W (PAD_FRAME_W)
    ) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .word  ({req_chan, req_code}),
        .shift (rise_evt),
        .sdata (dac_sdata)
    );

    assign req_ready  = (state == ST_IDLE);
    assign busy       = (state != ST_IDLE);
    assign dac_sclk   = sclk_q;
    assign dac_sync_n = sync_q;

endmodule

// File: rtl/dacseq_master_chk.sv
module dacseq_master_chk #(
    parameter int unsigned WORD_W     = 19,
    parameter int unsigned FRAME_W    = 24,
    parameter int unsigned GAP_CYCLES = 28
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic dac_sync_n,
    input logic dac_sclk,
    input logic dac_sdata
);

    logic        sclk_d;
    logic        sync_d;
    logic [7:0]  fall_cnt;
    int unsigned since_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d     <= 1'b1;
            sync_d     <= 1'b1;
            fall_cnt   <= '0;
            since_fall <= 32'd1000000;
        end else begin
            sclk_d <= dac_sclk;
            sync_d <= dac_sync_n;
            if (sync_d && !dac_sync_n) begin
                fall_cnt <= '0;
            end else if (sclk_d && !dac_sclk) begin
                fall_cnt <= fall_cnt + 8'd1;
            end
            if (sclk_d && !dac_sclk) begin
                since_fall <= 1;
            end else if (since_fall < 32'd1000000) begin
                since_fall <= since_fall + 1;
            end
        end
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && busy && !dac_sync_n)); // R2

    AST_SCLK_FALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> $stable(dac_sdata)); // R3

    AST_SCLK_HIGH_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sync_n |-> dac_sclk); // R5

    AST_FRAME_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sync_n) |-> ((fall_cnt == 8'(WORD_W)) || (fall_cnt == 8'(FRAME_W)))); // R6

    AST_SYNC_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sync_n) |-> dac_sclk); // R7

    AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sync_n) |-> (since_fall >= GAP_CYCLES)); // R8

    AST_NO_ACCEPT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sync_n |-> !req_ready); // R10

endmodule

bind dacseq_master dacseq_master_chk #(
    .WORD_W     (CHAN_W + CODE_W),
    .FRAME_W    (PAD_FRAME_W),
    .GAP_CYCLES (GAP_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .busy       (busy),
    .dac_sync_n (dac_sync_n),
    .dac_sclk   (dac_sclk),
    .dac_sdata  (dac_sdata)
);

// File: tb/dacseq_master_test.sv
module dacseq_master_test;

    localparam int unsigned HALF = 2;
    localparam int unsigned GAP  = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_chan = '0;
    logic [13:0] req_code = '0;
    logic        pad_mode = 1'b0;
    logic        req_ready, busy, dac_sync_n, dac_sclk, dac_sdata;

    always #5 clk = ~clk;

    dacseq_master #(
        .SYS_PERIOD_PS (10000),
        .HALF_DIV      (HALF),
        .GAP_CYCLES    (GAP)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_chan   (req_chan),
        .req_code   (req_code),
        .pad_mode   (pad_mode),
        .req_ready  (req_ready),
        .busy       (busy),
        .dac_sync_n (dac_sync_n),
        .dac_sclk   (dac_sclk),
        .dac_sdata  (dac_sdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int sent   = 0;

    logic [18:0] exp_word[$];
    bit          exp_pad[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int frame_len(input bit pad);
        return pad ? 24 : 19;
    endfunction

    function automatic logic [18:0] frame_word(input logic [23:0] bits, input bit pad);
        return pad ? bits[23:5] : bits[18:0];
    endfunction

    // Pin-level monitor, sampled on the falling system-clock edge
    bit          mon_on = 0;
    int          cyc = 0;
    bit          prev_sclk = 1, prev_sync = 1, prev_ready = 1;
    bit          in_frame = 0, after_frame = 0, phase_ok = 1, idle_ok = 1;
    int          t_sync_fall = 0, t_last_fall = 0, t_last_edge = 0;
    int          nbits = 0, frames_seen = 0;
    logic [23:0] shin = '0;

    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (dac_sync_n && !dac_sclk) idle_ok = 0;
            if (prev_sync && !dac_sync_n) begin
                in_frame = 1;
                t_sync_fall = cyc;
                t_last_edge = cyc;
                nbits = 0;
                shin = '0;
                phase_ok = 1;
                chk(busy && !req_ready, "R2", "busy,ready at frame start", {busy, req_ready}, 2);
                if (frames_seen > 0)
                    chk(cyc - t_last_fall >= int'(GAP) + 2, "R8", "strobe spacing",
                        cyc - t_last_fall, GAP + 2);
            end
            if (in_frame && prev_sclk && !dac_sclk) begin
                nbits++;
                shin = {shin[22:0], dac_sdata};
                if (nbits == 1)
                    chk(cyc - t_sync_fall == int'(HALF), "R4", "strobe to first fall",
                        cyc - t_sync_fall, HALF);
                else if (cyc - t_last_edge != int'(HALF))
                    phase_ok = 0;
                t_last_edge = cyc;
                t_last_fall = cyc;
            end
            if (in_frame && !prev_sclk && dac_sclk && !dac_sync_n) begin
                if (cyc - t_last_edge != int'(HALF)) phase_ok = 0;
                t_last_edge = cyc;
            end
            if (in_frame && !prev_sync && dac_sync_n) begin
                in_frame = 0;
                frames_seen++;
                chk(dac_sclk && (cyc - t_last_fall == int'(HALF)), "R7", "strobe rise delay",
                    cyc - t_last_fall, HALF);
                chk(phase_ok, "R5", "clock phase lengths", phase_ok, 1);
                if (exp_word.size() == 0) begin
                    chk(0, "R10", "unexpected frame", frames_seen, sent);
                end else begin
                    automatic logic [18:0] ew = exp_word.pop_front();
                    automatic bit          ep = exp_pad.pop_front();
                    chk(nbits == frame_len(ep), "R6", "falling edges per frame", nbits, frame_len(ep));
                    chk(frame_word(shin, ep) == ew, "R3", "frame word", frame_word(shin, ep), ew);
                    if (ep) chk(shin[4:0] == 5'd0, "R6", "pad bits", shin[4:0], 0);
                    if (ep != pad_mode) chk(1, "R9", "pad_mode flipped mid-frame", 0, 0);
                end
                after_frame = 1;
            end
            if (after_frame && !prev_ready && req_ready) begin
                chk(cyc - t_last_fall == int'(GAP) + 1, "R8", "ready return delay",
                    cyc - t_last_fall, GAP + 1);
                after_frame = 0;
            end
            prev_sclk  = dac_sclk;
            prev_sync  = dac_sync_n;
            prev_ready = req_ready;
        end
    end

    // Offer one request; optionally drive junk while the frame runs (R9, R10)
    task automatic send(input logic [4:0] ch, input logic [13:0] cd,
                        input bit pad, input bit junk);
        @(negedge clk);
        req_valid = 1'b1;
        req_chan  = ch;
        req_code  = cd;
        pad_mode  = pad;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        exp_word.push_back({ch, cd});
        exp_pad.push_back(pad);
        sent++;
        req_valid = 1'b0;
        if (junk) begin
            req_valid = 1'b1;
            req_chan  = ~ch;
            req_code  = ~cd;
            pad_mode  = ~pad;
            repeat (6) @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", frames_seen, sent);
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk({dac_sync_n, dac_sclk, dac_sdata, req_ready, busy} == 5'b11010, "R1",
            "outputs in reset", {dac_sync_n, dac_sclk, dac_sdata, req_ready, busy}, 5'b11010);
        rst_n = 1'b1;
        @(negedge clk);
        chk({dac_sync_n, dac_sclk, dac_sdata, req_ready, busy} == 5'b11010, "R1",
            "outputs after reset", {dac_sync_n, dac_sclk, dac_sdata, req_ready, busy}, 5'b11010);
        mon_on = 1;

        // Directed corners
        send(5'd31, 14'h3FFF, 1'b0, 1'b0);
        send(5'd0,  14'h0000, 1'b1, 1'b0);
        send(5'd21, 14'h2AAA, 1'b1, 1'b1);
        send(5'd10, 14'h1555, 1'b0, 1'b1);
        send(5'd31, 14'h3FFF, 1'b1, 1'b0);

        // Random traffic, back-to-back and spaced
        for (int i = 0; i < 40; i++) begin
            automatic logic [4:0]  ch  = 5'($urandom % 32);
            automatic logic [13:0] cd  = 14'($urandom % 16384);
            automatic bit          pd  = bit'($urandom % 2);
            automatic bit          jk  = ($urandom % 4) == 0;
            send(ch, cd, pd, jk);
            repeat ($urandom % 4) @(negedge clk);
        end

        while (frames_seen < sent) @(negedge clk);
        repeat (GAP + 10) @(negedge clk);
        chk(frames_seen == sent, "R10", "frame count", frames_seen, sent);
        chk(idle_ok, "R5", "clock high outside frames", idle_ok, 1);
        chk(req_ready && !busy && dac_sync_n, "R2", "idle at end", req_ready, 1);
        summary();
    end

endmodule